// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares the rising edges of a reference clock and a feedback clock. Both arrive as asynchronous digital levels and are sampled by a fast system clock. It produces one three-level correction output for a PLL loop filter. The output pumps high while the reference leads, pumps low while the feedback leads, and floats once the edges line up. On the ports the floating condition is a drive-enable plus drive-value pair, so the pad wrapper can build the actual tri-state buffer.

Each input goes through a synchroniser and a registered rising-edge detector. The filtered edges then step a three-state machine: a reference edge moves it one step toward "pump up", a feedback edge moves it one step toward "pump down", and two edges in the same cycle cancel. Duty cycle plays no part. Because the machine saturates in a state and does not toggle, it also detects frequency error. A feedback that is too fast is always pulled down, one that is too slow is always pulled up, and the loop cannot settle on a harmonic.

A registered lock flag rises after a parameterised number of consecutive reference periods in which the feedback edge landed in the same system-clock cycle as the reference edge or in the cycle next to it. The flag is held low in any cycle where a correction pulse is being driven.

Top module: `pfd_tristate_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: after that edge `drive_en` is 0 and `lock_det` is 0.
- R2: Only rising edges matter. Two inputs whose rising edges coincide give no correction and reach lock, even when their high times differ.
- R3: Output encoding: pump-up state gives `drive_en`=1 and `drive_val`=1. Pump-down state gives `drive_en`=1 and `drive_val`=0. Idle gives `drive_en`=0 (released).
- R4: A reference rising edge moves the state one step toward pump-up (down→idle, idle→up, up stays). A feedback rising edge moves it one step toward pump-down. Both in the same sampled cycle leave the state unchanged.
- R5: An input level first sampled high at clock edge k changes the output after clock edge k+3 (two synchroniser flops, an edge register, the state register).
- R6: With both inputs at the same frequency and the reference leading by d cycles, every high pulse lasts exactly d cycles and no low drive occurs.
- R7: With the feedback leading by d cycles, every low pulse lasts exactly d cycles and no high drive occurs.
- R8: With no reference activity and a toggling feedback, the output drives low continuously from the first feedback edge onward.
- R9: A feedback at twice the reference frequency produces net low drive. A feedback at half the reference frequency produces net high drive.
- R10: Each reference edge is judged aligned if a feedback edge lies in the same cycle or in the cycle just before or after it. `lock_det` becomes 1 after LOCK_PERIODS (default 4) consecutive aligned reference edges, with the result visible one cycle after the edge that follows the judged reference edge. A misaligned reference edge clears the count.
- R11: `lock_det` is 0 in every cycle in which `drive_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference clock, asynchronous level |
| fb_in | input | 1 | Feedback clock, asynchronous level |
| drive_en | output | 1 | 1 = correction output driven, 0 = released (high impedance) |
| drive_val | output | 1 | Driven level when `drive_en` is 1 (1 = up, 0 = down) |
| lock_det | output | 1 | Lock indication |

## Verification
Equal-frequency square waves with the reference leading, then lagging, by a fixed offset show that pulse width and polarity follow the phase error. Exactly aligned edges and edges one cycle apart separate true lock from the adjacent-cycle tolerance of the lock counter. Feedback at double and at half the reference frequency, and feedback with the reference silent, confirm that frequency error is always corrected in the right direction. Coincident edges with very different duty cycles, plus random periods, offsets and duty cycles, are compared cycle by cycle against a bench model of the edge-stepping state machine and the lock counter.

// File: rtl/pfd_pkg.sv
// Package: shared types and channel indices for the tri-state phase detector.
// Assumes a two-channel arrangement (reference, feedback).
package pfd_pkg;

    // Three-level correction state; encoding 2'b11 is never used.
    typedef enum logic [1:0] {
        PD_IDLE = 2'b00,
        PD_UP   = 2'b01,
        PD_DN   = 2'b10
    } pd_state_e;

    localparam int unsigned PD_CH_REF = 0;
    localparam int unsigned PD_CH_FB  = 1;
    localparam int unsigned PD_NUM_CH = 2;

endpackage

// File: rtl/pfd_sync.sv
// Module: multi-flop level synchroniser.
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes STAGES >= 2 and a synchronous active-low reset that clears the chain.
module pfd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pfd_edge.sv
// Module: registered rising-edge detector.
// Emits a one-cycle pulse, one cycle after a synchronised level goes 0 -> 1.
// Assumes the input is already in the clk domain.
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise_pulse
);

    logic prev_q;
    logic pulse_q;

    // Remember the previous level and register the rise condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= level;
            pulse_q <= level & ~prev_q;
        end
    end

    assign rise_pulse = pulse_q;

endmodule

// File: rtl/pfd_state.sv
// Module: three-state edge-stepping core of the detector.
// A reference edge steps toward PD_UP, a feedback edge toward PD_DN.
// Simultaneous edges cancel. The state saturates at both ends, which
// makes the detector frequency sensitive as well as phase sensitive.
// Assumes single-cycle edge pulses.
module pfd_state
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_step,
    input  logic      dn_step,
    output pd_state_e state_q
);

    pd_state_e state_d;

    // Next-state selection from the two step requests.
    always_comb begin
        state_d = state_q;
        if (up_step && !dn_step) begin
            case (state_q)
                PD_DN:   state_d = PD_IDLE;
                PD_IDLE: state_d = PD_UP;
                default: state_d = PD_UP;
            endcase
        end else if (dn_step && !up_step) begin
            case (state_q)
                PD_UP:   state_d = PD_IDLE;
                PD_IDLE: state_d = PD_DN;
                default: state_d = PD_DN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pfd_lock.sv
// Module: lock qualifier.
// Judges every reference edge one cycle after it occurs: aligned when a
// feedback edge sits in the cycle before, the same cycle, or the cycle after.
// Counts consecutive aligned edges up to LOCK_PERIODS. The flag is forced low
// while a correction pulse is being driven.
// Assumes single-cycle edge pulses from pfd_edge.
module pfd_lock #(
    parameter int unsigned LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_edge,
    input  logic fb_edge,
    input  logic correcting,
    output logic lock_det
);

    localparam int unsigned CNT_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_PERIODS);

    logic             ref_d_q;
    logic             fb_d_q;
    logic             fb_dd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             aligned;

    // Delay line that gives a three-cycle window around each reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_d_q <= 1'b0;
            fb_d_q  <= 1'b0;
            fb_dd_q <= 1'b0;
        end else begin
            ref_d_q <= ref_edge;
            fb_d_q  <= fb_edge;
            fb_dd_q <= fb_d_q;
        end
    end

    // Feedback edge in the window: cycle after, same cycle, or cycle before.
    assign aligned = fb_edge | fb_d_q | fb_dd_q;

    // Saturating counter of consecutive aligned reference edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ref_d_q) begin
            if (!aligned) begin
                cnt_q <= '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lock_det = (cnt_q == CNT_MAX) && !correcting;

endmodule

// File: rtl/pfd_tristate_top.sv
// Module: tri-state phase-frequency detector top.
// Synchronises the reference and feedback inputs, extracts their rising
// edges, steps the three-state core and drives a drive-enable/drive-value
// pair plus a lock flag. The tri-state buffer itself lives in the pad ring.
// Assumes clk is several times faster than either input clock.
module pfd_tristate_top
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned LOCK_PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    output logic drive_en,
    output logic drive_val,
    output logic lock_det
);

    logic [PD_NUM_CH-1:0] raw_lvl;
    logic [PD_NUM_CH-1:0] sync_lvl;
    logic [PD_NUM_CH-1:0] rise;
    logic                 ref_edge;
    logic                 fb_edge;
    pd_state_e            state_q;

    assign raw_lvl[PD_CH_REF] = ref_in;
    assign raw_lvl[PD_CH_FB]  = fb_in;

    // One synchroniser and one edge detector per input channel.
    for (genvar ch = 0; ch < PD_NUM_CH; ch++) begin : g_chan
        pfd_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_lvl[ch]),
            .sync_out (sync_lvl[ch])
        );

        pfd_edge u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .level      (sync_lvl[ch]),
            .rise_pulse (rise[ch])
        );
    end

    assign ref_edge = rise[PD_CH_REF];
    assign fb_edge  = rise[PD_CH_FB];

    pfd_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_step (ref_edge),
        .dn_step (fb_edge),
        .state_q (state_q)
    );

    // Released in idle; otherwise drive high for UP, low for DN.
    assign drive_en  = (state_q != PD_IDLE);
    assign drive_val = (state_q == PD_UP);

    pfd_lock #(
        .LOCK_PERIODS (LOCK_PERIODS)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge   (ref_edge),
        .fb_edge    (fb_edge),
        .correcting (drive_en),
        .lock_det   (lock_det)
    );

endmodule

// File: rtl/pfd_tristate_chk.sv
// Module: protocol checker for pfd_tristate_top, attached by bind.
// Observes ports and the internal state/edge signals.
module pfd_tristate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       drive_en,
    input logic       drive_val,
    input logic       lock_det,
    input logic [1:0] state_q,
    input logic       ref_edge,
    input logic       fb_edge
);

    localparam logic [1:0] S_IDLE = 2'b00;
    localparam logic [1:0] S_UP   = 2'b01;
    localparam logic [1:0] S_DN   = 2'b10;

    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> (!drive_en && !lock_det));

    assert_legal_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11);

    assert_no_up_to_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UP) |=> (state_q != S_DN));

    assert_no_dn_to_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DN) |=> (state_q != S_UP));

    assert_up_needs_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UP && $past(state_q) == S_IDLE) |-> ($past(ref_edge) && !$past(fb_edge)));

    assert_dn_needs_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DN && $past(state_q) == S_IDLE) |-> ($past(fb_edge) && !$past(ref_edge)));

    assert_lock_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_det |-> !drive_en);

    assert_release_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en) |-> (state_q == S_IDLE));

endmodule

bind pfd_tristate_top pfd_tristate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_en  (drive_en),
    .drive_val (drive_val),
    .lock_det  (lock_det),
    .state_q   (state_q),
    .ref_edge  (ref_edge),
    .fb_edge   (fb_edge)
);

// File: tb/sim_pfd_tristate_top.sv
module sim_pfd_tristate_top;

    localparam int LOCKN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic drive_en, drive_val, lock_det;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // model state: 0 idle, 1 up, 2 down
    int       m_st;
    int       m_cnt;
    logic     m_lr, m_lf;
    logic [7:0] rh, fh;

    // scenario statistics
    int  hi_cnt, lo_cnt, lk_cnt, fl_after_lo, run_hi, run_lo;
    bit  seen_lo;
    int  pw_hi_exp, pw_lo_exp;

    always #2 clk = ~clk;

    pfd_tristate_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .drive_en  (drive_en),
        .drive_val (drive_val),
        .lock_det  (lock_det)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    function automatic int next_state(input int st, input bit r, input bit f);
        if (r && !f) return (st == 2) ? 0 : 1;
        if (f && !r) return (st == 1) ? 0 : 2;
        return st;
    endfunction

    task automatic clear_stats();
        hi_cnt = 0; lo_cnt = 0; lk_cnt = 0; fl_after_lo = 0;
        run_hi = 0; run_lo = 0; seen_lo = 0;
        pw_hi_exp = 0; pw_lo_exp = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
        m_st = 0; m_cnt = 0; m_lr = 0; m_lf = 0; rh = '0; fh = '0;
        // R1: released and unlocked after reset edges
        check(drive_en === 1'b0, "R1 drive_en", int'(drive_en), 0);
        check(lock_det === 1'b0, "R1 lock_det", int'(lock_det), 0);
        rst_n = 1'b1;
        clear_stats();
    endtask

    // One sampled cycle: drive at negedge, compare after the posedge.
    task automatic step(input logic r, input logic f);
        bit en_e, val_e, lk_e, al;
        @(negedge clk);
        ref_in = r; fb_in = f;
        @(posedge clk);
        #1;
        cyc++;
        rh = {rh[6:0], r & ~m_lr};
        fh = {fh[6:0], f & ~m_lf};
        m_lr = r; m_lf = f;
        m_st = next_state(m_st, rh[3], fh[3]);
        if (rh[4]) begin
            al = fh[3] | fh[4] | fh[5];
            if (!al) m_cnt = 0;
            else if (m_cnt < LOCKN) m_cnt++;
        end
        en_e  = (m_st != 0);
        val_e = (m_st == 1);
        lk_e  = (m_cnt == LOCKN) && !en_e;
        check(drive_en === en_e, "R4/R5 drive_en", int'(drive_en), int'(en_e));
        if (en_e) check(drive_val === val_e, "R3 drive_val", int'(drive_val), int'(val_e));
        check(lock_det === lk_e, "R10/R11 lock_det", int'(lock_det), int'(lk_e));
        // statistics and pulse-width tracking
        if (drive_en && drive_val) begin
            hi_cnt++; run_hi++;
        end else begin
            if (run_hi > 0 && pw_hi_exp > 0) check(run_hi == pw_hi_exp, "R6 high width", run_hi, pw_hi_exp);
            run_hi = 0;
        end
        if (drive_en && !drive_val) begin
            lo_cnt++; run_lo++; seen_lo = 1;
        end else begin
            if (run_lo > 0 && pw_lo_exp > 0) check(run_lo == pw_lo_exp, "R7 low width", run_lo, pw_lo_exp);
            run_lo = 0;
            if (seen_lo) fl_after_lo++;
        end
        if (lock_det) lk_cnt++;
    endtask

    // Square waves: period, high time and delay per input; ref optionally silent.
    task automatic waves(input int pr, input int hr, input int dr,
                         input int pf, input int hf, input int df,
                         input int n, input bit ref_on);
        for (int c = 0; c < n; c++) begin
            logic r, f;
            r = ref_on && (c >= dr) && (((c - dr) % pr) < hr);
            f = (c >= df) && (((c - df) % pf) < hf);
            step(r, f);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired cycle=%0d actual=%0d expected=%0d", cyc, 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));

        // R5: single reference edge reaches the output after the third edge
        do_reset();
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        check(drive_en === 1'b0, "R5 not yet", int'(drive_en), 0);
        step(1'b1, 1'b0);
        check(drive_en === 1'b1 && drive_val === 1'b1, "R5 high now", int'({drive_en, drive_val}), 3);

        // R6: reference leads by 3
        do_reset();
        pw_hi_exp = 3;
        waves(16, 8, 0, 16, 8, 3, 200, 1'b1);
        check(lo_cnt == 0, "R6 no low drive", lo_cnt, 0);
        check(hi_cnt > 0, "R6 high seen", hi_cnt, 1);

        // R7: feedback leads by 2
        do_reset();
        pw_lo_exp = 2;
        waves(16, 8, 2, 16, 8, 0, 200, 1'b1);
        check(hi_cnt == 0, "R7 no high drive", hi_cnt, 0);
        check(lo_cnt > 0, "R7 low seen", lo_cnt, 1);

        // R10: exact alignment reaches lock, never drives
        do_reset();
        waves(12, 6, 0, 12, 6, 0, 200, 1'b1);
        check(hi_cnt + lo_cnt == 0, "R10 aligned no drive", hi_cnt + lo_cnt, 0);
        check(lock_det === 1'b1, "R10 aligned locked", int'(lock_det), 1);

        // R10: one-cycle offset still counts as aligned
        do_reset();
        waves(12, 6, 0, 12, 6, 1, 200, 1'b1);
        check(lk_cnt > 0, "R10 adjacent locks", lk_cnt, 1);

        // R10: two-cycle offset never locks
        do_reset();
        waves(12, 6, 0, 12, 6, 2, 200, 1'b1);
        check(lk_cnt == 0, "R10 offset two no lock", lk_cnt, 0);

        // R2: same rising edges, very different duty cycles
        do_reset();
        waves(16, 2, 0, 16, 13, 0, 200, 1'b1);
        check(hi_cnt + lo_cnt == 0, "R2 duty ignored", hi_cnt + lo_cnt, 0);
        check(lock_det === 1'b1, "R2 duty lock", int'(lock_det), 1);

        // R8: reference silent, feedback toggling
        do_reset();
        waves(16, 8, 0, 10, 5, 0, 200, 1'b0);
        check(hi_cnt == 0, "R8 no high", hi_cnt, 0);
        check(fl_after_lo == 0, "R8 continuous low", fl_after_lo, 0);
        check(lo_cnt > 150, "R8 low count", lo_cnt, 151);

        // R9: feedback at twice the reference frequency
        do_reset();
        waves(16, 8, 0, 8, 4, 0, 300, 1'b1);
        check(lo_cnt > hi_cnt, "R9 fast fb net low", lo_cnt, hi_cnt + 1);

        // R9: feedback at half the reference frequency
        do_reset();
        waves(16, 8, 0, 32, 16, 0, 300, 1'b1);
        check(hi_cnt > lo_cnt, "R9 slow fb net high", hi_cnt, lo_cnt + 1);

        // Random rounds, checked cycle by cycle against the model
        for (int k = 0; k < 20; k++) begin
            int pr, pf, hr, hf, dr, df;
            do_reset();
            pr = 6 + int'($urandom_range(34));
            pf = ($urandom_range(3) == 0) ? 6 + int'($urandom_range(34)) : pr;
            hr = 1 + int'($urandom_range(pr - 2));
            hf = 1 + int'($urandom_range(pf - 2));
            dr = int'($urandom_range(5));
            df = int'($urandom_range(5));
            waves(pr, hr, dr, pf, hf, df, 300, 1'b1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule